// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block holds a full wall-clock date and time as packed BCD fields (seconds, minutes, hours in 24-hour form, day of week, date, month and two-digit year) and moves them forward by one second whenever a one-cycle tick pulse arrives. A carry out of the seconds field ripples through minutes, hours, date, month and year in the same clock cycle. The last date of each month is derived from the current month and year, so February is 29 days long in leap years. A century flag can be enabled so that it inverts each time the year wraps from 99 back to 00.

Software sets the clock through a parallel load strobe that writes every field at once, including the century enable and century flag. A stop input freezes counting while still allowing loads. The oscillator, the prescaler that makes the tick, and any bus interface are outside this block.

Top module: `bcd_calendar`

## Requirements
- R1: While rst_n is low the fields reset to 00:00:00, day of week 1, date 01, month 01, year 00, with the century enable and century flag both 0.
- R2: Seconds and minutes count 00 to 59 and hours 00 to 23 in packed BCD (tens digit in bits 7:4, ones digit in bits 3:0); a field at its top value returns to 00 on an advance and carries into the next field in the same cycle.
- R3: A field advance happens on a rising clock edge only when tick is 1, stop is 0 and load is 0; the outputs show the new value after that edge. With tick 0 or stop 1 (and load 0) every output holds its value.
- R4: The date runs from 01 up to the last date of the month and then returns to 01 while the month advances: 30 for months 04, 06, 09 and 11; 31 for 01, 03, 05, 07, 08, 10 and 12; 28 for 02 in a common year and 29 in a leap year.
- R5: A year is a leap year when its two-digit value is divisible by 4; year 00 is a leap year.
- R6: Month counts 01 to 12; an advance past month 12 sets month 01 and advances the year, and the year wraps from 99 to 00.
- R7: The day-of-week field (bits 2:0) counts 1 to 7, advances on each advance that moves the date, and goes from 7 back to 1.
- R8: On a year wrap from 99 to 00 the century flag inverts when the century enable is 1 and holds when it is 0; it never changes at any other advance.
- R9: When load is 1 on a rising edge, every field, the century enable and the century flag take the values on the load inputs after that edge, regardless of tick and stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, one per second |
| stop | input | 1 | Freezes counting while 1 |
| load | input | 1 | Writes all load inputs into the fields |
| ld_sec | input | 8 | Seconds value to load, BCD |
| ld_min | input | 8 | Minutes value to load, BCD |
| ld_hour | input | 8 | Hours value to load, BCD |
| ld_wday | input | 3 | Day-of-week value to load, 1 to 7 |
| ld_date | input | 8 | Date value to load, BCD |
| ld_month | input | 8 | Month value to load, BCD |
| ld_year | input | 8 | Year value to load, BCD |
| ld_cen_en | input | 1 | Century enable value to load |
| ld_cen | input | 1 | Century flag value to load |
| sec | output | 8 | Current seconds, BCD |
| min | output | 8 | Current minutes, BCD |
| hour | output | 8 | Current hours, BCD |
| wday | output | 3 | Current day of week |
| date | output | 8 | Current date, BCD |
| month | output | 8 | Current month, BCD |
| year | output | 8 | Current year, BCD |
| cen_en | output | 1 | Current century enable |
| cen | output | 1 | Current century flag |

## Verification
The range properties take for granted that every load carries valid BCD digits, in-range field values, a day of week from 1 to 7, and a date that exists in the loaded month and year; an impossible calendar entry would otherwise be reported as a counter fault. The bench keeps to this by drawing each load value as a binary number inside the range for its field, taking the date limit from the drawn month and year, and only then converting to BCD. Random loads are biased toward the top of each field so that multi-field carries, month ends and year wraps occur often.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned BCD_W      = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned WDAY_W     = 3;
  localparam int unsigned WDAY_LAST  = 7;

  localparam int unsigned F_SEC   = 0;
  localparam int unsigned F_MIN   = 1;
  localparam int unsigned F_HOUR  = 2;
  localparam int unsigned F_DATE  = 3;
  localparam int unsigned F_MONTH = 4;
  localparam int unsigned F_YEAR  = 5;

  typedef logic [BCD_W-1:0]  bcd_t;
  typedef logic [WDAY_W-1:0] wday_t;

  // Add one to a two-digit BCD value (no wrap handling here).
  function automatic bcd_t bcd_next(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisibility by 4 read from the digits: an even tens digit needs
  // ones of 0/4/8, an odd tens digit needs ones of 2/6.
  function automatic logic leap_year(bcd_t y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic bcd_t month_end(bcd_t m, bcd_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Lowest value of each counted field.
  function automatic bcd_t field_floor(int unsigned idx);
    return (idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction

  // Fixed upper bound of each field; the date bound is computed at run time.
  function automatic bcd_t field_top(int unsigned idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_MONTH:      return 8'h12;
      F_YEAR:       return 8'h99;
      default:      return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter bcd_t FLOOR     = 8'h00,
  parameter bcd_t RESET_VAL = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  bcd_t load_val,
  input  logic step,
  input  bcd_t ceiling,
  output bcd_t value,
  output logic wrap
);
  logic at_top;

  assign at_top = (value >= ceiling);
  assign wrap   = step && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= RESET_VAL;
    else if (load) value <= load_val;
    else if (step) value <= at_top ? FLOOR : bcd_next(value);
  end
endmodule

// File: rtl/cal_aux_state.sv
module cal_aux_state
  import cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  wday_t ld_wday,
  input  logic  ld_cen_en,
  input  logic  ld_cen,
  input  logic  day_step,
  input  logic  year_roll,
  output wday_t wday,
  output logic  cen_en,
  output logic  cen
);
  localparam wday_t WD_LAST  = wday_t'(WDAY_LAST);
  localparam wday_t WD_FIRST = wday_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday   <= WD_FIRST;
      cen_en <= 1'b0;
      cen    <= 1'b0;
    end else if (load) begin
      wday   <= ld_wday;
      cen_en <= ld_cen_en;
      cen    <= ld_cen;
    end else begin
      if (day_step) wday <= (wday >= WD_LAST) ? WD_FIRST : wday + WD_FIRST;
      if (year_roll && cen_en) cen <= ~cen;
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       stop,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic       ld_cen_en,
  input  logic       ld_cen,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [2:0] wday,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       cen_en,
  output logic       cen
);
  bcd_t                  ld_vec   [NUM_FIELDS];
  bcd_t                  val_vec  [NUM_FIELDS];
  bcd_t                  ceil_vec [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] step_vec;
  logic [NUM_FIELDS-1:0] wrap_vec;

  // Named internal events, used by the bound checker.
  logic advance;
  logic day_roll;
  logic year_roll;

  assign advance   = tick && !stop && !load;
  assign day_roll  = wrap_vec[F_HOUR];
  assign year_roll = wrap_vec[F_YEAR];

  assign ld_vec[F_SEC]   = ld_sec;
  assign ld_vec[F_MIN]   = ld_min;
  assign ld_vec[F_HOUR]  = ld_hour;
  assign ld_vec[F_DATE]  = ld_date;
  assign ld_vec[F_MONTH] = ld_month;
  assign ld_vec[F_YEAR]  = ld_year;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == 0) begin : g_first
      assign step_vec[g] = advance;
    end else begin : g_chain
      assign step_vec[g] = wrap_vec[g-1];
    end

    if (g == F_DATE) begin : g_var_top
      assign ceil_vec[g] = month_end(val_vec[F_MONTH], val_vec[F_YEAR]);
    end else begin : g_fix_top
      assign ceil_vec[g] = field_top(g);
    end

    cal_bcd_field #(
      .FLOOR    (field_floor(g)),
      .RESET_VAL(field_floor(g))
    ) u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(ld_vec[g]),
      .step    (step_vec[g]),
      .ceiling (ceil_vec[g]),
      .value   (val_vec[g]),
      .wrap    (wrap_vec[g])
    );
  end

  cal_aux_state u_aux (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_wday  (ld_wday),
    .ld_cen_en(ld_cen_en),
    .ld_cen   (ld_cen),
    .day_step (day_roll),
    .year_roll(year_roll),
    .wday     (wday),
    .cen_en   (cen_en),
    .cen      (cen)
  );

  assign sec   = val_vec[F_SEC];
  assign min   = val_vec[F_MIN];
  assign hour  = val_vec[F_HOUR];
  assign date  = val_vec[F_DATE];
  assign month = val_vec[F_MONTH];
  assign year  = val_vec[F_YEAR];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_date,
  input logic [7:0] ld_year,
  input logic       ld_cen,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [2:0] wday,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       cen_en,
  input logic       cen,
  input logic       advance,
  input logic       day_roll,
  input logic       year_roll
);
  logic last_second;
  assign last_second = advance && sec == 8'h59 && min == 8'h59 && hour == 8'h23;

  a_r1_field_ranges: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= 8'h59 && sec[3:0] <= 4'd9 && min <= 8'h59 && hour <= 8'h23 &&
    date >= 8'h01 && date <= 8'h31 && month >= 8'h01 && month <= 8'h12 &&
    wday >= 3'd1 && wday <= 3'd7);

  a_r2_second_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sec == 8'h59) |=> (sec == 8'h00 && min != $past(min)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
      $stable(wday) && $stable(date) && $stable(month) && $stable(year) && $stable(cen)));

  a_r4_month_end_31: assert property (@(posedge clk) disable iff (!rst_n)
    (last_second && date == 8'h31) |=> (date == 8'h01 && month != $past(month)));

  a_r6_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_second && date == 8'h31 && month == 8'h12 && year == 8'h99)
      |=> (year == 8'h00 && month == 8'h01));

  a_r7_wday_step: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> (($past(wday) == 3'd7) ? (wday == 3'd1) : (wday == $past(wday) + 3'd1)));

  a_r8_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(year_roll && cen_en)) |=> $stable(cen));

  a_r8_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (year_roll && cen_en) |=> (cen != $past(cen)));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec == $past(ld_sec) && date == $past(ld_date) &&
      year == $past(ld_year) && cen == $past(ld_cen)));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .ld_sec   (ld_sec),
  .ld_date  (ld_date),
  .ld_year  (ld_year),
  .ld_cen   (ld_cen),
  .sec      (sec),
  .min      (min),
  .hour     (hour),
  .wday     (wday),
  .date     (date),
  .month    (month),
  .year     (year),
  .cen_en   (cen_en),
  .cen      (cen),
  .advance  (advance),
  .day_roll (day_roll),
  .year_roll(year_roll)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, stop = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_date = '0, ld_month = '0, ld_year = '0;
  logic [2:0] ld_wday = '0;
  logic       ld_cen_en = 1'b0, ld_cen = 1'b0;
  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] wday;
  logic       cen_en, cen;

  int total = 0;
  int fails = 0;

  // Reference state in plain binary.
  int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y;
  bit m_ce, m_c;
  int p_s, p_mi, p_h, p_wd, p_d, p_mo, p_y;
  bit p_ce, p_c;

  always #2.5 clk = ~clk;

  bcd_calendar uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
    .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
    .ld_cen_en(ld_cen_en), .ld_cen(ld_cen),
    .sec(sec), .min(min), .hour(hour), .wday(wday), .date(date),
    .month(month), .year(year), .cen_en(cen_en), .cen(cen)
  );

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_wd = (m_wd % 7) + 1;
    m_d++;
    if (m_d <= days_in(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y <= 99) return;
    m_y = 0;
    if (m_ce) m_c = ~m_c;
  endtask

  task automatic check_state(string tag);
    logic [63:0] act, exp;
    act = {sec, min, hour, 5'd0, wday, date, month, year, 6'd0, cen_en, cen};
    exp = {to_bcd(m_s), to_bcd(m_mi), to_bcd(m_h), 5'd0, 3'(m_wd), to_bcd(m_d),
           to_bcd(m_mo), to_bcd(m_y), 6'd0, m_ce, m_c};
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Put a binary value set on the load inputs (held until the next call).
  task automatic stage(int y, int mo, int d, int h, int mi, int s, int wd, bit ce, bit c);
    p_y = y; p_mo = mo; p_d = d; p_h = h; p_mi = mi; p_s = s; p_wd = wd; p_ce = ce; p_c = c;
    ld_year = to_bcd(y); ld_month = to_bcd(mo); ld_date = to_bcd(d);
    ld_hour = to_bcd(h); ld_min = to_bcd(mi); ld_sec = to_bcd(s);
    ld_wday = 3'(wd); ld_cen_en = ce; ld_cen = c;
  endtask

  // Called at a falling edge: drive, take one rising edge, check at the next falling edge.
  task automatic cycle(bit t, bit st, bit ld, string tag);
    tick = t; stop = st; load = ld;
    @(posedge clk);
    if (ld) begin
      m_y = p_y; m_mo = p_mo; m_d = p_d; m_h = p_h; m_mi = p_mi; m_s = p_s;
      m_wd = p_wd; m_ce = p_ce; m_c = p_c;
    end else if (t && !st) begin
      model_advance();
    end
    @(negedge clk);
    tick = 1'b0; load = 1'b0;
    check_state(tag);
  endtask

  // Load a moment, then give it one tick.
  task automatic corner(int y, int mo, int d, int h, int mi, int s, int wd, bit ce, bit c,
                        string tag);
    stage(y, mo, d, h, mi, s, wd, ce, c);
    cycle(1'b0, 1'b0, 1'b1, "R9");
    cycle(1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20240517);
    m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0; m_ce = 0; m_c = 0;
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // Plain counting from reset.
    cycle(1'b1, 1'b0, 1'b0, "R2");
    cycle(1'b0, 1'b0, 1'b0, "R3");

    // Leap February in year 04, then out of its 29th.
    corner(4, 2, 28, 23, 59, 59, 3, 1'b0, 1'b0, "R5");
    corner(4, 2, 29, 23, 59, 59, 4, 1'b0, 1'b0, "R4");
    // Common February in year 03.
    corner(3, 2, 28, 23, 59, 59, 5, 1'b0, 1'b0, "R4");
    // Year 00 is leap.
    corner(0, 2, 28, 23, 59, 59, 2, 1'b0, 1'b0, "R5");
    // Year 99 end with century enabled and disabled.
    corner(99, 12, 31, 23, 59, 59, 6, 1'b1, 1'b0, "R8");
    corner(99, 12, 31, 23, 59, 59, 6, 1'b0, 1'b1, "R8");
    corner(98, 12, 31, 23, 59, 59, 1, 1'b1, 1'b0, "R6");
    // 30-day months, plus 31-day checks around them.
    corner(21, 4, 30, 23, 59, 59, 1, 1'b0, 1'b0, "R4");
    corner(21, 6, 30, 23, 59, 59, 2, 1'b0, 1'b0, "R4");
    corner(21, 9, 30, 23, 59, 59, 3, 1'b0, 1'b0, "R4");
    corner(21, 11, 30, 23, 59, 59, 4, 1'b0, 1'b0, "R4");
    corner(21, 1, 30, 23, 59, 59, 5, 1'b0, 1'b0, "R4");
    corner(21, 1, 31, 23, 59, 59, 6, 1'b0, 1'b0, "R4");
    // Day of week wrap.
    corner(22, 3, 10, 23, 59, 59, 7, 1'b0, 1'b0, "R7");
    // Minute and hour carries without a date change.
    corner(22, 3, 10, 9, 59, 59, 7, 1'b0, 1'b0, "R2");

    // Stop freezes the count; release resumes.
    stage(15, 7, 4, 10, 59, 59, 2, 1'b1, 1'b1);
    cycle(1'b0, 1'b0, 1'b1, "R9");
    cycle(1'b1, 1'b1, 1'b0, "R3");
    cycle(1'b1, 1'b1, 1'b0, "R3");
    cycle(1'b1, 1'b0, 1'b0, "R2");

    // Load together with a tick, and load while stopped.
    stage(40, 8, 31, 23, 59, 59, 7, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 1'b1, "R9");
    stage(50, 5, 5, 5, 5, 5, 5, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, "R9");
    cycle(1'b1, 1'b0, 1'b0, "R3");

    // Random stretches started from loads biased to field tops.
    for (int i = 0; i < 1500; i++) begin
      if (i % 25 == 0) begin
        int y, mo, dm;
        y  = (($urandom % 4) == 0) ? 99 : int'($urandom % 100);
        mo = (($urandom % 3) == 0) ? 12 : 1 + int'($urandom % 12);
        dm = days_in(mo, y);
        stage(y, mo, dm - int'($urandom % 2), 22 + int'($urandom % 2),
              58 + int'($urandom % 2), 50 + int'($urandom % 10),
              1 + int'($urandom % 7), 1'($urandom), 1'($urandom));
        cycle(1'($urandom), 1'($urandom), 1'b1, "R9");
      end else begin
        cycle(($urandom % 5) != 0, ($urandom % 10) == 0, 1'b0, "R2");
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule